// File: doc/BRIEF.md
# Compare Output Pin Override Unit

This block sits between a timer channel and one general-purpose port pin. It keeps a single-bit compare state register. A compare-match strobe or a force strobe changes that register by an action chosen with a two-bit mode field. The choices are to toggle it, to clear it, to set it, or to leave it alone.

The same mode field decides what drives the pin value. When the mode is zero, the ordinary port data bit drives the pin. When the mode is non-zero, the compare state drives the pin instead. Direction is never taken over: the pin output enable always follows the port's direction bit. Software can therefore preset the compare state while the pin is still an input. The pin then shows that level as soon as the direction bit is set.

Top module: `cmp_pin_ovr`

## Requirements
- R1: An active-low reset (`rst_n` = 0) clears the compare state to 0 at once. After release, with mode 11 and direction 1 and no strobe, the pin value is 0.
- R2: With mode 00, the pin value equals `port_data_i`. A match or force strobe in mode 00 leaves the compare state unchanged.
- R3: With mode 01, 10 or 11, the pin value equals the compare state and ignores `port_data_i`.
- R4: Mode 01 toggles the compare state on a strobe. The new value appears on the pin in the cycle after the capturing clock edge.
- R5: Mode 10 clears the compare state on a strobe.
- R6: Mode 11 sets the compare state on a strobe.
- R7: The force strobe `force_i` applies the same mode action as `match_i`, at the same clock edge.
- R8: Match and force asserted in the same cycle apply the action once. In mode 01 this is a single toggle.
- R9: `pin_oe_o` always equals `port_dir_i`, whatever the mode. When `port_dir_i` is 0, `pin_out_o` is held at 0.
- R10: Strobes update the compare state while `port_dir_i` is 0. The preset level appears on `pin_out_o` once the direction is 1 and the mode is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | I/O clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the compare state |
| mode_i | input | 2 | Action/source select: 00 off, 01 toggle, 10 clear, 11 set |
| match_i | input | 1 | Compare-match strobe, one cycle per event |
| force_i | input | 1 | Force strobe; applies the mode action without a match |
| port_data_i | input | 1 | Ordinary port data bit |
| port_dir_i | input | 1 | Port direction bit, 1 = output |
| pin_out_o | output | 1 | Value presented to the pin driver |
| pin_oe_o | output | 1 | Pin driver enable |

## Verification
The hardest state to reach from the ports is a compare state that differs from what the pin currently shows. This happens when the state is preset with the pin undriven, or while mode 00 hands the pin to the port data. That hidden state is only revealed later, when the direction or the mode changes. The stimulus table therefore sets the state with the direction at 0 and then passes through mode 00 with opposite port data. Only after that does it select a non-zero mode with no strobe, so the stored level must appear unchanged. Coincident match and force in toggle mode is driven directly to show that the action is applied once.

// File: rtl/cmp_ovr_pkg.sv
package cmp_ovr_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    CM_OFF = 2'b00,
    CM_TOG = 2'b01,
    CM_CLR = 2'b10,
    CM_SET = 2'b11
  } cmp_mode_e;

  // Next value of the compare state after an update event.
  function automatic logic cmp_next(input cmp_mode_e mode, input logic cur);
    logic nxt;
    case (mode)
      CM_TOG:  nxt = ~cur;
      CM_CLR:  nxt = 1'b0;
      CM_SET:  nxt = 1'b1;
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

  // Non-zero mode hands the pin value over to the compare state.
  function automatic logic cmp_overrides(input cmp_mode_e mode);
    return mode != CM_OFF;
  endfunction

endpackage

// File: rtl/cmp_state_reg.sv
module cmp_state_reg
  import cmp_ovr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cmp_mode_e mode,
  input  logic      upd_evt,
  output logic      state_q
);

  logic state_d;

  always_comb begin
    state_d = state_q;
    if (upd_evt) state_d = cmp_next(mode, state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= 1'b0;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/cmp_pin_mux.sv
module cmp_pin_mux
  import cmp_ovr_pkg::*;
(
  input  logic      ovr_en,
  input  logic      cmp_state,
  input  logic      port_data,
  input  logic      port_dir,
  output logic      pin_out,
  output logic      pin_oe
);

  logic src_bit;

  always_comb begin
    src_bit = ovr_en ? cmp_state : port_data;
    pin_oe  = port_dir;
    pin_out = src_bit & port_dir;
  end

endmodule

// File: rtl/cmp_pin_ovr.sv
module cmp_pin_ovr
  import cmp_ovr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              match_i,
  input  logic              force_i,
  input  logic              port_data_i,
  input  logic              port_dir_i,
  output logic              pin_out_o,
  output logic              pin_oe_o
);

  cmp_mode_e mode;
  logic      upd_evt;   // one update per cycle, match or force or both
  logic      ovr_en;    // compare state owns the pin value
  logic      cmp_state;

  assign mode    = cmp_mode_e'(mode_i);
  assign upd_evt = match_i | force_i;
  assign ovr_en  = cmp_overrides(mode);

  cmp_state_reg u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .upd_evt (upd_evt),
    .state_q (cmp_state)
  );

  cmp_pin_mux u_mux (
    .ovr_en    (ovr_en),
    .cmp_state (cmp_state),
    .port_data (port_data_i),
    .port_dir  (port_dir_i),
    .pin_out   (pin_out_o),
    .pin_oe    (pin_oe_o)
  );

endmodule

// File: rtl/cmp_pin_ovr_chk.sv
module cmp_pin_ovr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       match_i,
  input logic       force_i,
  input logic       port_data_i,
  input logic       port_dir_i,
  input logic       pin_out_o,
  input logic       pin_oe_o,
  input logic       cmp_state
);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(match_i || force_i) || mode_i == 2'b00) |=> $stable(cmp_state));

  p_port_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe_o && mode_i == 2'b00) |-> pin_out_o == port_data_i);

  p_cmp_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe_o && mode_i != 2'b00) |-> pin_out_o == cmp_state);

  p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((match_i || force_i) && mode_i == 2'b01) |=> cmp_state != $past(cmp_state));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((match_i || force_i) && mode_i == 2'b10) |=> !cmp_state);

  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((match_i || force_i) && mode_i == 2'b11) |=> cmp_state);

  p_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (match_i && force_i && mode_i == 2'b01) |=> cmp_state != $past(cmp_state));

  p_oe_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe_o == port_dir_i);

  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !port_dir_i |-> !pin_out_o);

endmodule

bind cmp_pin_ovr cmp_pin_ovr_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .match_i     (match_i),
  .force_i     (force_i),
  .port_data_i (port_data_i),
  .port_dir_i  (port_dir_i),
  .pin_out_o   (pin_out_o),
  .pin_oe_o    (pin_oe_o),
  .cmp_state   (cmp_state)
);

// File: tb/cmp_pin_ovr_tb.sv
`timescale 1ns/1ps
module cmp_pin_ovr_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_i = 2'b00;
  logic       match_i = 1'b0, force_i = 1'b0;
  logic       port_data_i = 1'b0, port_dir_i = 1'b0;
  logic       pin_out_o, pin_oe_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmp_pin_ovr u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .match_i(match_i),
    .force_i(force_i), .port_data_i(port_data_i), .port_dir_i(port_dir_i),
    .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o)
  );

  // {mode[1:0], match, force, data, dir, expected pin_out after the edge}
  localparam logic [6:0] VEC [16] = '{
    7'b00_0_0_1_1_1, // R2 port drives
    7'b00_1_0_0_1_0, // R2 match ignored, state stays 0
    7'b11_0_0_1_1_0, // R3 state 0 shown over data 1
    7'b11_1_0_0_1_1, // R6 set
    7'b10_0_0_1_1_1, // R3 no strobe, hold
    7'b10_1_0_1_1_0, // R5 clear
    7'b01_1_0_0_1_1, // R4 toggle up
    7'b01_1_0_0_1_0, // R4 toggle down
    7'b01_0_1_0_1_1, // R7 force toggles
    7'b01_1_1_0_1_0, // R8 both strobes, one toggle
    7'b11_0_1_1_0_0, // R10 preset set while pin undriven, R9 gated
    7'b00_0_0_0_1_0, // R2 port data hides state
    7'b10_0_0_0_1_1, // R10 preset now visible
    7'b10_0_1_1_1_0, // R7 force clear
    7'b00_1_0_1_1_1, // R2 match in mode 00
    7'b01_0_0_1_1_0  // R2 state untouched by previous step
  };

  function automatic string vec_tag(input int k);
    case (k)
      2, 4:         return "R3";
      3:            return "R6";
      5:            return "R5";
      6, 7:         return "R4";
      8, 13:        return "R7";
      9:            return "R8";
      10, 12:       return "R10";
      default:      return "R2";
    endcase
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic mt, input logic fc,
                      input logic d, input logic dr);
    @(negedge clk);
    mode_i = m; match_i = mt; force_i = fc; port_data_i = d; port_dir_i = dr;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: state cleared by reset, shown through a non-zero mode
    step(2'b11, 1'b0, 1'b0, 1'b1, 1'b1);
    check(pin_out_o, 1'b0, "R1");
    check(pin_oe_o, 1'b1, "R9");

    for (int k = 0; k < 16; k++) begin
      step(VEC[k][6:5], VEC[k][4], VEC[k][3], VEC[k][2], VEC[k][1]);
      check(pin_out_o, VEC[k][0], vec_tag(k));
      check(pin_oe_o, VEC[k][1], "R9");
    end

    // R1: mid-run reset clears a set state asynchronously
    step(2'b11, 1'b0, 1'b1, 1'b0, 1'b1);
    check(pin_out_o, 1'b1, "R6");
    @(negedge clk);
    force_i = 1'b0;
    rst_n = 1'b0;
    #1;
    check(pin_out_o, 1'b0, "R1");
    check(pin_oe_o, 1'b1, "R9");
    @(negedge clk);
    rst_n = 1'b1;
    step(2'b11, 1'b0, 1'b0, 1'b0, 1'b1);
    check(pin_out_o, 1'b0, "R1");

    // R9: direction low gates even port data in mode 00
    step(2'b00, 1'b0, 1'b0, 1'b1, 1'b0);
    check(pin_oe_o, 1'b0, "R9");
    check(pin_out_o, 1'b0, "R9");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule